// File: doc/BRIEF.md
# Clock Source Selector and Prescaler

This block selects the clock that drives a microcontroller core and derives the peripheral clocks. Everything runs in one reference clock domain. Each oscillator shows up as a one-cycle tick strobe, and every derived clock leaves the block as a one-cycle enable strobe, so no real clock is ever muxed or gated. A two-bit mode field picks the core source: the main crystal, the sub crystal, or the internal oscillator. The internal oscillator is the fast or the slow on-chip oscillator, chosen by a select bit, and it counts only while that oscillator's on bit is set. A prescaler divides the selected ticks by 1, 2, 4, 8 or 16 to form the CPU enable.

The timer, fast-timer and voltage-monitor enables do not depend on the mode. Each one follows only its own oscillator gating.

A request for low-current flash reads is granted only when the current source and divide ratio permit it. The request is accepted only once the requested divide ratio is actually in force. The grant is withdrawn in the same cycle that the configuration stops permitting it. Control and status pins are plain levels, with no handshake.

Top module: `clksel_top`

## Requirements
- R1: `cpu_en` pulses once per 2^k selected source ticks, where k is `div_sel` (0..4 give divide-by 1, 2, 4, 8, 16; codes 5..7 act as 4). Each pulse appears in the cycle after the tick that completes the count.
- R2: `mode_sel` 00 selects the main crystal, 01 the sub crystal and 10 the internal oscillator. `cur_mode` shows the registered mode one cycle later. The code 11 leaves `cur_mode` unchanged, and `mode_err` is high in each cycle that follows a cycle in which 11 was applied.
- R3: In internal mode, the source tick is `tick_fast` gated by `fast_on` when `int_fast_sel`=1, and `tick_slow` gated by `slow_on` when `int_fast_sel`=0.
- R4: `fast_tmr_en` equals `fast_on & tick_fast` of the previous cycle, in every mode.
- R5: `vmon_en` equals `slow_on & tick_slow` of the previous cycle, in every mode.
- R6: `tmr_en` equals the internal-oscillator tick of R3 from the previous cycle, in every mode.
- R7: With the sub crystal as the effective mode, a grant is possible only for divide codes 0..3, and only while SUB_HZ/2^k exceeds 3000 Hz.
- R8: With the internal oscillator as the effective mode, a grant is possible only when `int_fast_sel`=0, `slow_on`=1 and the clamped divide code is 2..4. The main-crystal mode never permits a grant.
- R9: A grant is first raised in the cycle after `lcr_req` is seen while the configuration permits it and the divide ratio in force already equals the clamped `div_sel`. It is kept while `lcr_req` stays high and the configuration still permits it.
- R10: `lcr_ok` drops in the same cycle that `mode_sel`, `div_sel`, `int_fast_sel` or `slow_on` moves to a setting that does not permit a grant. The effective mode is `mode_sel`, or `cur_mode` when `mode_sel`=11.
- R11: A new divide ratio is loaded only at a prescaler boundary, so no CPU enable interval is ever cut short.
- R12: After reset every enable output, `mode_err` and `lcr_ok` are 0, `cur_mode` is 00, and the ratio in force is divide-by-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_main | input | 1 | Main crystal tick strobe |
| tick_sub | input | 1 | Sub crystal tick strobe |
| tick_fast | input | 1 | Fast internal oscillator tick strobe |
| tick_slow | input | 1 | Slow internal oscillator tick strobe |
| fast_on | input | 1 | Fast internal oscillator running |
| slow_on | input | 1 | Slow internal oscillator running |
| int_fast_sel | input | 1 | Internal source: 1 fast, 0 slow |
| mode_sel | input | 2 | Source mode request |
| div_sel | input | DIV_W | Divide exponent request |
| lcr_req | input | 1 | Low-current read request |
| cpu_en | output | 1 | CPU clock enable strobe |
| tmr_en | output | 1 | General timer clock enable |
| fast_tmr_en | output | 1 | Fast timer clock enable |
| vmon_en | output | 1 | Voltage monitor clock enable |
| cur_mode | output | 2 | Mode in force |
| mode_err | output | 1 | Reserved mode code was applied |
| lcr_ok | output | 1 | Low-current read granted |

## Verification
The hardest state to reach from the ports is a live grant followed by a divide change. The new ratio is already permitted, but the grant must be held while the old ratio is still in force until the next boundary. A different change must instead revoke the grant in the same cycle.

The stimulus holds the sub-crystal and slow-oscillator modes for long phases. Source ticks are sparse and random, so prescaler boundaries are far apart. `div_sel` and `lcr_req` are changed at random during those phases. A behavioural model then compares every output on every cycle.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_SUB  = 2'b01,
    SRC_INT  = 2'b10,
    SRC_RSVD = 2'b11
  } src_mode_e;

  // largest divide exponent allowed for low-current reads on the sub crystal
  localparam int SUB_LCR_MAX_EXP  = 3;
  // smallest divide exponent allowed for low-current reads on the slow oscillator
  localparam int SLOW_LCR_MIN_EXP = 2;
endpackage

// File: rtl/clksel_source_mux.sv
module clksel_source_mux
  import clksel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_main,
  input  logic      tick_sub,
  input  logic      tick_fast,
  input  logic      tick_slow,
  input  logic      fast_on,
  input  logic      slow_on,
  input  logic      int_fast_sel,
  input  logic [1:0] mode_sel,
  output src_mode_e cur_mode,
  output src_mode_e eff_mode,
  output logic      mode_err,
  output logic      src_tick,
  output logic      tmr_en,
  output logic      fast_tmr_en,
  output logic      vmon_en
);
  logic oco_tick;

  always_comb begin
    eff_mode = (mode_sel == 2'b11) ? cur_mode : src_mode_e'(mode_sel);
    oco_tick = int_fast_sel ? (fast_on & tick_fast) : (slow_on & tick_slow);
    case (cur_mode)
      SRC_MAIN: src_tick = tick_main;
      SRC_SUB:  src_tick = tick_sub;
      SRC_INT:  src_tick = oco_tick;
      default:  src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode    <= SRC_MAIN;
      mode_err    <= 1'b0;
      tmr_en      <= 1'b0;
      fast_tmr_en <= 1'b0;
      vmon_en     <= 1'b0;
    end else begin
      cur_mode    <= eff_mode;
      mode_err    <= (mode_sel == 2'b11);
      tmr_en      <= oco_tick;
      fast_tmr_en <= fast_on & tick_fast;
      vmon_en     <= slow_on & tick_slow;
    end
  end

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != SRC_RSVD);
  assert_fast_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_tmr_en |-> $past(fast_on));
  assert_vmon_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vmon_en |-> $past(slow_on));
endmodule

// File: rtl/clksel_prescaler.sv
module clksel_prescaler #(
  parameter int MAX_EXP = 4,
  localparam int EXP_W = $clog2(MAX_EXP + 1),
  localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [EXP_W-1:0] div_exp,
  output logic [EXP_W-1:0] applied_exp,
  output logic             cpu_en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             at_end;

  always_comb begin
    lim    = CNT_W'((32'd1 << applied_exp) - 32'd1);
    at_end = (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      applied_exp <= '0;
      cpu_en      <= 1'b0;
    end else begin
      cpu_en <= src_tick & at_end;
      if (src_tick) begin
        if (at_end) begin
          cnt         <= '0;
          applied_exp <= div_exp; // new ratio only at a boundary
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_ratio_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (applied_exp != $past(applied_exp)) |-> cpu_en);
  assert_cpu_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> $past(src_tick));
endmodule

// File: rtl/clksel_lcr_gate.sv
module clksel_lcr_gate
  import clksel_pkg::*;
#(
  parameter int SUB_HZ     = 32768,
  parameter int LCR_MIN_HZ = 3000,
  parameter int EXP_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_mode_e        eff_mode,
  input  logic             int_fast_sel,
  input  logic             slow_on,
  input  logic [EXP_W-1:0] div_exp,
  input  logic [EXP_W-1:0] applied_exp,
  input  logic             lcr_req,
  output logic             lcr_ok
);
  logic permit;
  logic lcr_q;

  always_comb begin
    case (eff_mode)
      SRC_SUB: permit = (int'(div_exp) <= SUB_LCR_MAX_EXP) &&
                        ((SUB_HZ >> div_exp) > LCR_MIN_HZ);
      SRC_INT: permit = !int_fast_sel && slow_on &&
                        (int'(div_exp) >= SLOW_LCR_MIN_EXP);
      default: permit = 1'b0;
    endcase
    lcr_ok = lcr_q & permit; // revoke in the same cycle
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lcr_q <= 1'b0;
    else        lcr_q <= lcr_req && permit && (lcr_q || (applied_exp == div_exp));
  end

  assert_grant_after_ratio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcr_q) |-> $past(applied_exp == div_exp && lcr_req));
  assert_main_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == SRC_MAIN) |-> !lcr_ok);
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int MAX_EXP    = 4,
  parameter int SUB_HZ     = 32768,
  parameter int LCR_MIN_HZ = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_main,
  input  logic             tick_sub,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             fast_on,
  input  logic             slow_on,
  input  logic             int_fast_sel,
  input  logic [1:0]       mode_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             lcr_req,
  output logic             cpu_en,
  output logic             tmr_en,
  output logic             fast_tmr_en,
  output logic             vmon_en,
  output logic [1:0]       cur_mode,
  output logic             mode_err,
  output logic             lcr_ok
);
  localparam int EXP_W = $clog2(MAX_EXP + 1);

  src_mode_e        cur_mode_e;
  src_mode_e        eff_mode;
  logic             src_tick;
  logic [EXP_W-1:0] div_exp;
  logic [EXP_W-1:0] applied_exp;

  always_comb begin
    if (int'(div_sel) > MAX_EXP) div_exp = EXP_W'(MAX_EXP);
    else                         div_exp = EXP_W'(div_sel);
    cur_mode = cur_mode_e;
  end

  clksel_source_mux u_mux (
    .clk, .rst_n, .tick_main, .tick_sub, .tick_fast, .tick_slow,
    .fast_on, .slow_on, .int_fast_sel, .mode_sel,
    .cur_mode(cur_mode_e), .eff_mode, .mode_err, .src_tick,
    .tmr_en, .fast_tmr_en, .vmon_en
  );

  clksel_prescaler #(.MAX_EXP(MAX_EXP)) u_div (
    .clk, .rst_n, .src_tick, .div_exp, .applied_exp, .cpu_en
  );

  clksel_lcr_gate #(.SUB_HZ(SUB_HZ), .LCR_MIN_HZ(LCR_MIN_HZ), .EXP_W(EXP_W)) u_lcr (
    .clk, .rst_n, .eff_mode, .int_fast_sel, .slow_on,
    .div_exp, .applied_exp, .lcr_req, .lcr_ok
  );
endmodule

// File: tb/clksel_top_test.sv
module clksel_top_test;
  localparam int SUB_HZ = 32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_main = 0, tick_sub = 0, tick_fast = 0, tick_slow = 0;
  logic fast_on = 0, slow_on = 0, int_fast_sel = 0, lcr_req = 0;
  logic [1:0] mode_sel = 0;
  logic [2:0] div_sel = 0;
  logic cpu_en, tmr_en, fast_tmr_en, vmon_en, mode_err, lcr_ok;
  logic [1:0] cur_mode;

  int errors = 0, checks = 0;
  bit done = 0;
  // behavioural reference state
  int m_mode = 0, m_cnt = 0, m_ap = 0;
  bit m_err = 0, m_cpu = 0, m_tmr = 0, m_ftmr = 0, m_vmon = 0, m_lq = 0;
  int grants_sub = 0, grants_slow = 0, rsvd_seen = 0;

  always #2 clk = ~clk;

  clksel_top uut (
    .clk, .rst_n, .tick_main, .tick_sub, .tick_fast, .tick_slow,
    .fast_on, .slow_on, .int_fast_sel, .mode_sel, .div_sel, .lcr_req,
    .cpu_en, .tmr_en, .fast_tmr_en, .vmon_en, .cur_mode, .mode_err, .lcr_ok
  );

  function automatic bit permit_f(int eff, int dv, bit isel, bit so);
    if (eff == 1) return (dv <= 3) && ((SUB_HZ / (1 << dv)) > 3000);
    if (eff == 2) return !isel && so && (dv >= 2);
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    int eff, dv, lim, src, oco;
    bit perm, nq;
    eff = (mode_sel == 3) ? m_mode : int'(mode_sel);
    dv  = (div_sel > 4) ? 4 : int'(div_sel);
    oco = int_fast_sel ? int'(fast_on & tick_fast) : int'(slow_on & tick_slow);
    src = (m_mode == 0) ? int'(tick_main) : (m_mode == 1) ? int'(tick_sub) : oco;
    lim = (1 << m_ap) - 1;
    perm = permit_f(eff, dv, int_fast_sel, slow_on);
    nq = lcr_req && perm && (m_lq || m_ap == dv);
    m_cpu = (src != 0) && (m_cnt == lim);
    if (src != 0) begin
      if (m_cnt == lim) begin m_cnt = 0; m_ap = dv; end
      else m_cnt++;
    end
    m_tmr = (oco != 0); m_ftmr = fast_on & tick_fast; m_vmon = slow_on & tick_slow;
    m_lq = nq;
    m_err = (mode_sel == 3);
    if (mode_sel != 3) m_mode = mode_sel;
    @(posedge clk); @(negedge clk);
    eff = (mode_sel == 3) ? m_mode : int'(mode_sel);
    perm = permit_f(eff, dv, int_fast_sel, slow_on);
    chk("R1 R11 cpu_en", cpu_en, m_cpu);
    chk("R3 R6 tmr_en", tmr_en, m_tmr);
    chk("R4 fast_tmr_en", fast_tmr_en, m_ftmr);
    chk("R5 vmon_en", vmon_en, m_vmon);
    chk("R2 cur_mode", cur_mode, m_mode);
    chk("R2 mode_err", mode_err, m_err);
    chk("R7 R8 R9 R10 lcr_ok", lcr_ok, m_lq && perm);
    if (lcr_ok && eff == 1) grants_sub++;
    if (lcr_ok && eff == 2) grants_slow++;
    if (mode_err) rsvd_seen++;
  endtask

  // mode < 0 lets the configuration wander at random
  task automatic run(input int cycles, input int mode, input bit isel, input bit fo, input bit so);
    for (int i = 0; i < cycles; i++) begin
      tick_main = ($urandom % 3) == 0; tick_sub = ($urandom % 3) == 0;
      tick_fast = ($urandom % 2) == 0; tick_slow = ($urandom % 3) == 0;
      if (($urandom % 12) == 0) div_sel = 3'($urandom % 8);
      if (($urandom % 9) == 0) lcr_req = !lcr_req;
      if (mode >= 0) begin
        mode_sel = 2'(mode); int_fast_sel = isel; fast_on = fo; slow_on = so;
      end else begin
        if (($urandom % 10) == 0) mode_sel = 2'($urandom % 4);
        if (($urandom % 15) == 0) int_fast_sel = !int_fast_sel;
        if (($urandom % 15) == 0) fast_on = !fast_on;
        if (($urandom % 15) == 0) slow_on = !slow_on;
      end
      step();
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset cpu_en", cpu_en, 0);
    chk("R12 reset cur_mode", cur_mode, 0);
    chk("R12 reset lcr_ok", lcr_ok, 0);
    chk("R12 reset mode_err", mode_err, 0);
    chk("R12 reset tmr_en", tmr_en | fast_tmr_en | vmon_en, 0);
    rst_n = 1'b1;
    run(600, 0, 0, 1, 1);   // main crystal, divide changes
    run(2000, 1, 0, 1, 1);  // sub crystal with low-current reads
    run(2000, 2, 0, 0, 1);  // slow internal oscillator
    run(800, 2, 1, 1, 0);   // fast internal oscillator
    run(300, 2, 0, 0, 0);   // internal selected but stopped
    run(200, 3, 0, 1, 1);   // reserved code held
    run(6000, -1, 0, 1, 1); // everything random
    chk("R7 grant seen on sub crystal", int'(grants_sub > 0), 1);
    chk("R8 grant seen on slow oscillator", int'(grants_slow > 0), 1);
    chk("R2 reserved code observed", int'(rsvd_seen > 0), 1);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule